// File: doc/BRIEF.md
# UART Interrupt Source Controller

This block turns the state of a UART's transmit and receive paths into one interrupt request. It looks at the transmit and receive FIFO occupancy counts and compares each against a programmable trigger level. It also runs a receive-idle timer counted in character times, and it accepts single-cycle error and modem event strobes. Each of these conditions sets a bit in a source-pending register. A mask register suppresses chosen bits. A masked pending register holds the unmasked sources, and the interrupt line is high whenever that register is nonzero.

The trigger levels are scaled by a multiplier fixed by the channel-number parameter, so one design serves channels with deep and shallow FIFOs. Software clears interrupts by writing ones. Writing to the masked pending register clears both registers. Writing to the source register clears only the source bits and leaves the masked view unchanged until the next evaluation. An evaluation happens on a cycle that has a set request, a mask write or a pending write.

The block carries no data stream, so it has no valid/ready interface. Every input is a plain level or a single-cycle strobe, and no back-pressure applies. The FIFOs, the serial engines and the baud generator sit outside it. The baud block supplies a bit tick and the number of bit ticks per character.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the source, mask and masked pending registers, the timeout flag and `irq` are all zero.
- R2: Source bit positions are fixed: bit 0 is receive, bit 1 is error, bit 2 is transmit and bit 3 is modem. On each evaluation the masked pending register becomes source AND NOT mask, and `irq` is high exactly when the masked pending register is nonzero. A mask write stores `wr_data` and counts as an evaluation.
- R3: A pending write (`wr_pend`) clears the bits that are set in `wr_data`, in both the source and the masked pending registers.
- R4: A source write (`wr_src`) clears the bits set in `wr_data` from the source register only. The masked pending register and `irq` stay unchanged until the next evaluation.
- R5: When `fifo_en` is 1, the transmit source (bit 2) sets in every cycle where `tx_count` is at most `tx_trig` times the multiplier. When `fifo_en` is 0, it never sets from counts.
- R6: When `fifo_en` is 1, the receive source (bit 0) sets when `rx_count` is at least (`rx_trig`+1) times the multiplier. Reaching this level also cancels a running idle timer.
- R7: When `fifo_en` is 1 and `tout_en` is 0, any nonzero `rx_count` sets the receive source. This condition also cancels a running idle timer.
- R8: The multiplier is 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel.
- R9: When `fifo_en` and `tout_en` are both 1, each `rx_push` loads the idle timer with `tout_len` times `char_bits` bit ticks and restarts it. With `bit_tick` high every cycle, the timer expires on the clock edge `tout_len*char_bits+1` after the push edge.
- R10: On expiry, the block sets the receive source and `tout_flag` only if receive data is present or `tout_force` is 1. Data is present when `rx_count` is nonzero with `fifo_en` at 1, or when `hold_ready` is 1 with `fifo_en` at 0. Otherwise expiry has no effect.
- R11: An idle timer cancelled by R6 or R7 never expires.
- R12: A status write (`wr_stat`) with `wr_data[3]` at 1 clears `tout_flag`. The other data bits are ignored. An expiry in the same cycle wins.
- R13: When `fifo_en` is 0, the receive source sets whenever `hold_ready` is 1.
- R14: An `err_evt` strobe sets bit 1 and a `modem_evt` strobe sets bit 3. A set in a cycle wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| tx_trig | input | TRIG_W | Transmit trigger field |
| rx_trig | input | TRIG_W | Receive trigger field (1 is added before scaling) |
| tout_en | input | 1 | Idle timeout enable |
| tout_len | input | LEN_W | Idle timeout length in characters |
| tout_force | input | 1 | Let expiry fire even with no data present |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| hold_ready | input | 1 | Holding register has data (FIFO disabled) |
| rx_push | input | 1 | Strobe: one byte received |
| err_evt | input | 1 | Strobe: error event |
| modem_evt | input | 1 | Strobe: modem event |
| bit_tick | input | 1 | Bit-time tick from the baud block |
| char_bits | input | BPC_W | Bit ticks per character |
| wr_pend | input | 1 | Write strobe: clear masked pending and source bits |
| wr_src | input | 1 | Write strobe: clear source bits only |
| wr_mask | input | 1 | Write strobe: load mask |
| wr_stat | input | 1 | Write strobe: status (bit 3 clears the timeout flag) |
| wr_data | input | 4 | Write data for all write strobes |
| src_q | output | 4 | Source-pending register |
| mask_q | output | 4 | Mask register |
| pend_q | output | 4 | Masked pending register |
| tout_flag | output | 1 | Timeout status flag |
| irq | output | 1 | Interrupt request |

## Verification
Every register result appears one clock edge after the stimulus that caused it. This covers the source, mask, masked pending, flag and `irq` outputs. The bench therefore drives inputs at a falling edge, waits one rising edge and samples at the next falling edge. Idle timeout tests keep `bit_tick` high and sample at edge L and at edge L+1 after the push edge, where L is `tout_len*char_bits`. The "no expiry" cases (no data present, cancelled timer) are sampled well past L+1. Random trigger-level trials compute the expected source bits in a bench function and return to a quiet state before the next trial.

// File: rtl/uic_pkg.sv
package uic_pkg;
  localparam int SRC_N     = 4;
  localparam int SRC_RX    = 0;
  localparam int SRC_ERR   = 1;
  localparam int SRC_TX    = 2;
  localparam int SRC_MODEM = 3;

  // Trigger-level scale factor chosen by channel number
  function automatic int unsigned chan_mult(input int unsigned ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/uic_levels.sv
module uic_levels #(
  parameter int          CNT_W   = 8,
  parameter int          TRIG_W  = 3,
  parameter int unsigned CHANNEL = 0
) (
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic [TRIG_W-1:0] rx_trig,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              tout_en,
  output logic              tx_hit,
  output logic              rx_hit
);
  localparam int unsigned MULT  = uic_pkg::chan_mult(CHANNEL);
  localparam int          LVL_W = (TRIG_W + 7 > CNT_W) ? TRIG_W + 7 : CNT_W + 1;

  logic [LVL_W-1:0] tx_lvl, rx_lvl;

  generate
    if (MULT == 0) begin : g_nomult
      assign tx_lvl = '0;
      assign rx_lvl = '0;
    end else begin : g_mult
      localparam logic [LVL_W-1:0] MULT_V = LVL_W'(MULT);
      assign tx_lvl = LVL_W'(tx_trig) * MULT_V;
      assign rx_lvl = (LVL_W'(rx_trig) + LVL_W'(1)) * MULT_V;
    end
  endgenerate

  always_comb begin
    tx_hit = LVL_W'(tx_count) <= tx_lvl;
    rx_hit = (LVL_W'(rx_count) >= rx_lvl) || ((rx_count != '0) && !tout_en);
  end
endmodule

// File: rtl/uic_timeout.sv
module uic_timeout #(
  parameter int LEN_W = 4,
  parameter int BPC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             push,
  input  logic             cancel,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  input  logic [BPC_W-1:0] char_bits,
  output logic             fire
);
  localparam int CW = LEN_W + BPC_W;

  logic [CW-1:0] cnt, load;
  logic          run;

  assign load = CW'(len) * CW'(char_bits);
  assign fire = run && (cnt == '0) && !cancel && enable && !push;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (cancel || !enable) begin
      run <= 1'b0;
    end else if (push) begin
      cnt <= load;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else if (tick) cnt <= cnt - 1'b1;
    end
  end

  a_r11_cancel_stops: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !run);
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (push && enable && !cancel) |=> (run && cnt == $past(load)));
  a_r9_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/uic_pending.sv
module uic_pending #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_req,
  input  logic         wr_pend,
  input  logic         wr_src,
  input  logic         wr_mask,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] src_q,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] clr, src_d, mask_d, pend_d;
  logic         eval;

  always_comb begin
    clr    = (wr_pend || wr_src) ? wr_data : '0;
    src_d  = (src_q & ~clr) | set_req;
    mask_d = wr_mask ? wr_data : mask_q;
    eval   = (|set_req) || wr_mask || wr_pend;
    pend_d = eval ? (src_d & ~mask_d) : pend_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_d;
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  a_r2_masked_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & mask_q) == '0);
  a_r3_pend_clears_src: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && (set_req & wr_data) == '0) |=> (src_q & $past(wr_data)) == '0);
  a_r4_src_write_holds_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_src && !wr_mask && !wr_pend && set_req == '0) |=> pend_q == $past(pend_q));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int          CNT_W   = 8,
  parameter int          TRIG_W  = 3,
  parameter int          LEN_W   = 4,
  parameter int          BPC_W   = 4,
  parameter int unsigned CHANNEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic [TRIG_W-1:0] rx_trig,
  input  logic              tout_en,
  input  logic [LEN_W-1:0]  tout_len,
  input  logic              tout_force,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              hold_ready,
  input  logic              rx_push,
  input  logic              err_evt,
  input  logic              modem_evt,
  input  logic              bit_tick,
  input  logic [BPC_W-1:0]  char_bits,
  input  logic              wr_pend,
  input  logic              wr_src,
  input  logic              wr_mask,
  input  logic              wr_stat,
  input  logic [3:0]        wr_data,
  output logic [3:0]        src_q,
  output logic [3:0]        mask_q,
  output logic [3:0]        pend_q,
  output logic              tout_flag,
  output logic              irq
);
  import uic_pkg::*;

  logic tx_hit, rx_hit, fire, fire_eff, rx_ready, cancel;
  logic [SRC_N-1:0] set_req;

  uic_levels #(.CNT_W(CNT_W), .TRIG_W(TRIG_W), .CHANNEL(CHANNEL)) u_levels (
    .tx_trig(tx_trig), .rx_trig(rx_trig), .tx_count(tx_count),
    .rx_count(rx_count), .tout_en(tout_en), .tx_hit(tx_hit), .rx_hit(rx_hit)
  );

  assign cancel = fifo_en && rx_hit;

  uic_timeout #(.LEN_W(LEN_W), .BPC_W(BPC_W)) u_timeout (
    .clk(clk), .rst_n(rst_n), .enable(fifo_en && tout_en), .push(rx_push),
    .cancel(cancel), .tick(bit_tick), .len(tout_len), .char_bits(char_bits),
    .fire(fire)
  );

  assign rx_ready = fifo_en ? (rx_count != '0) : hold_ready;
  assign fire_eff = fire && (rx_ready || tout_force);

  always_comb begin
    set_req            = '0;
    set_req[SRC_RX]    = (fifo_en ? rx_hit : hold_ready) || fire_eff;
    set_req[SRC_TX]    = fifo_en && tx_hit;
    set_req[SRC_ERR]   = err_evt;
    set_req[SRC_MODEM] = modem_evt;
  end

  uic_pending #(.N(SRC_N)) u_pending (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .wr_pend(wr_pend),
    .wr_src(wr_src), .wr_mask(wr_mask), .wr_data(wr_data),
    .src_q(src_q), .mask_q(mask_q), .pend_q(pend_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      tout_flag <= 1'b0;
    else if (fire_eff)               tout_flag <= 1'b1;
    else if (wr_stat && wr_data[3])  tout_flag <= 1'b0;
  end

  assign irq = |pend_q;

  a_r12_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wr_data[3] && !fire_eff) |=> !tout_flag);
  a_r10_flag_with_rx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tout_flag) |-> src_q[SRC_RX]);
  a_r14_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> src_q[SRC_ERR]);
  a_r14_modem_sets: assert property (@(posedge clk) disable iff (!rst_n)
    modem_evt |=> src_q[SRC_MODEM]);
endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en, tout_en, tout_force, hold_ready, rx_push, err_evt, modem_evt, bit_tick;
  logic wr_pend, wr_src, wr_mask, wr_stat;
  logic [2:0] tx_trig, rx_trig;
  logic [3:0] tout_len, char_bits, wr_data;
  logic [7:0] tx_count, rx_count;
  logic [3:0] src_q, mask_q, pend_q, src2, mask2, pend2;
  logic tout_flag, irq, flag2, irq2;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  uart_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_trig(tx_trig),
    .rx_trig(rx_trig), .tout_en(tout_en), .tout_len(tout_len), .tout_force(tout_force),
    .tx_count(tx_count), .rx_count(rx_count), .hold_ready(hold_ready), .rx_push(rx_push),
    .err_evt(err_evt), .modem_evt(modem_evt), .bit_tick(bit_tick), .char_bits(char_bits),
    .wr_pend(wr_pend), .wr_src(wr_src), .wr_mask(wr_mask), .wr_stat(wr_stat),
    .wr_data(wr_data), .src_q(src_q), .mask_q(mask_q), .pend_q(pend_q),
    .tout_flag(tout_flag), .irq(irq));

  uart_irq_ctrl #(.CHANNEL(3)) uut_ch3 (.clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .tx_trig(tx_trig), .rx_trig(rx_trig), .tout_en(tout_en), .tout_len(tout_len),
    .tout_force(tout_force), .tx_count(tx_count), .rx_count(rx_count),
    .hold_ready(hold_ready), .rx_push(rx_push), .err_evt(err_evt), .modem_evt(modem_evt),
    .bit_tick(bit_tick), .char_bits(char_bits), .wr_pend(wr_pend), .wr_src(wr_src),
    .wr_mask(wr_mask), .wr_stat(wr_stat), .wr_data(wr_data), .src_q(src2),
    .mask_q(mask2), .pend_q(pend2), .tout_flag(flag2), .irq(irq2));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Expected level-driven source bits for channel 0 (multiplier 32)
  function automatic logic [3:0] exp_lvl(input int tc, input int tt, input int rc,
                                         input int rt, input bit te);
    logic [3:0] e = 4'b0000;
    e[2] = (tc <= tt * 32);
    e[0] = (rc >= (rt + 1) * 32) || (rc != 0 && !te);
    return e;
  endfunction

  task automatic quiet_clear();
    tx_count = 8'd255; rx_count = 8'd0;
    wr_pend = 1'b1; wr_data = 4'hF; step(1); wr_pend = 1'b0;
  endtask

  task automatic lvl_trial(input int tc, input int tt, input int rc, input int rt,
                           input bit te, input string req);
    tx_count = tc[7:0]; tx_trig = tt[2:0]; rx_count = rc[7:0]; rx_trig = rt[2:0];
    tout_en = te;
    step(1);
    chk(req, src_q, exp_lvl(tc, tt, rc, rt, te));
    quiet_clear();
    tx_trig = 3'd0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    fifo_en = 1; tout_en = 1; tout_force = 0; hold_ready = 0; rx_push = 0;
    err_evt = 0; modem_evt = 0; bit_tick = 1; wr_pend = 0; wr_src = 0;
    wr_mask = 0; wr_stat = 0; tx_trig = 0; rx_trig = 0; tout_len = 2;
    char_bits = 10; wr_data = 0; tx_count = 8'd255; rx_count = 0;
    step(3); rst_n = 1'b1; step(1);
    // R1 reset state
    chk("R1 src", src_q, 0); chk("R1 mask", mask_q, 0); chk("R1 pend", pend_q, 0);
    chk("R1 flag", tout_flag, 0); chk("R1 irq", irq, 0);

    // R14 error strobe, R2 irq
    err_evt = 1; step(1); err_evt = 0;
    chk("R14 err src", src_q, 4'b0010); chk("R2 pend", pend_q, 4'b0010); chk("R2 irq", irq, 1);
    wr_mask = 1; wr_data = 4'b0010; step(1); wr_mask = 0;
    chk("R2 masked pend", pend_q, 0); chk("R2 masked irq", irq, 0); chk("R2 src kept", src_q, 4'b0010);
    wr_mask = 1; wr_data = 4'b0000; step(1); wr_mask = 0;
    chk("R2 unmask pend", pend_q, 4'b0010);
    // R3 pending write clears both
    wr_pend = 1; wr_data = 4'b0010; step(1); wr_pend = 0;
    chk("R3 src", src_q, 0); chk("R3 pend", pend_q, 0); chk("R3 irq", irq, 0);
    // R4 source write clears source only
    modem_evt = 1; step(1); modem_evt = 0;
    chk("R14 modem src", src_q, 4'b1000);
    wr_src = 1; wr_data = 4'b1000; step(1); wr_src = 0;
    chk("R4 src", src_q, 0); chk("R4 pend kept", pend_q, 4'b1000); chk("R4 irq kept", irq, 1);
    wr_mask = 1; wr_data = 4'b0000; step(1); wr_mask = 0;
    chk("R4 eval pend", pend_q, 0); chk("R4 eval irq", irq, 0);
    // R14 set wins over clear
    err_evt = 1; wr_src = 1; wr_data = 4'b0010; step(1); err_evt = 0; wr_src = 0;
    chk("R14 set wins", src_q, 4'b0010);
    quiet_clear();

    // R5/R6/R7 boundaries
    lvl_trial(64, 2, 0, 0, 1, "R5 tx at level");
    lvl_trial(65, 2, 0, 0, 1, "R5 tx above level");
    lvl_trial(255, 0, 31, 0, 1, "R6 rx below level");
    lvl_trial(255, 0, 32, 0, 1, "R6 rx at level");
    lvl_trial(255, 0, 1, 7, 0, "R7 rx data without timeout");
    lvl_trial(0, 0, 0, 0, 1, "R5 tx zero level");
    for (int i = 0; i < 24; i++)
      lvl_trial($urandom_range(0, 255), $urandom_range(0, 7), $urandom_range(0, 255),
                $urandom_range(0, 7), 1'($urandom_range(0, 1)), "R5/R6/R7 random");
    tout_en = 1;

    // R13 holding-register mode
    fifo_en = 0; hold_ready = 1; tx_count = 0; step(1);
    chk("R13 rx via holding, no tx", src_q, 4'b0001);
    hold_ready = 0; fifo_en = 1; quiet_clear();

    // R9/R10 timeout: L = 2*10 = 20
    rx_trig = 7; rx_count = 3; quiet_clear(); rx_count = 3;
    rx_push = 1; step(1); rx_push = 0; step(20);
    chk("R9 before expiry", {tout_flag, src_q[0]}, 0);
    step(1);
    chk("R9 expiry sets rx", src_q[0], 1); chk("R10 flag set", tout_flag, 1);
    wr_stat = 1; wr_data = 4'b0111; step(1); wr_stat = 0;
    chk("R12 other bits ignored", tout_flag, 1);
    wr_stat = 1; wr_data = 4'b1000; step(1); wr_stat = 0;
    chk("R12 flag cleared", tout_flag, 0);
    quiet_clear(); rx_count = 3;
    // R9 restart
    rx_push = 1; step(1); rx_push = 0; step(10);
    rx_push = 1; step(1); rx_push = 0; step(20);
    chk("R9 restart not yet", {tout_flag, src_q[0]}, 0);
    step(1);
    chk("R9 restart expiry", {tout_flag, src_q[0]}, 2'b11);
    wr_stat = 1; wr_pend = 1; wr_data = 4'hF; step(1); wr_stat = 0; wr_pend = 0;
    // R10 no data, no force
    rx_count = 0;
    rx_push = 1; step(1); rx_push = 0; step(24);
    chk("R10 no data no effect", {tout_flag, src_q[0]}, 0);
    tout_force = 1;
    rx_push = 1; step(1); rx_push = 0; step(20);
    chk("R10 forced not yet", {tout_flag, src_q[0]}, 0);
    step(1);
    chk("R10 forced expiry", {tout_flag, src_q[0]}, 2'b11);
    tout_force = 0;
    wr_stat = 1; wr_pend = 1; wr_data = 4'hF; step(1); wr_stat = 0; wr_pend = 0;
    // R11 cancel by reaching level
    rx_trig = 0; rx_count = 3;
    rx_push = 1; step(1); rx_push = 0; step(5);
    rx_count = 40; step(1);
    chk("R6 level reached", src_q[0], 1);
    rx_count = 3; wr_pend = 1; wr_data = 4'hF; step(1); wr_pend = 0;
    step(25);
    chk("R11 cancelled timer silent", {tout_flag, src_q[0]}, 0);

    // R8 channel 3 multiplier 2
    quiet_clear();
    tx_trig = 3; tx_count = 6; step(1);
    chk("R8 ch3 tx at level 6", src2[2], 1);
    tx_count = 7; wr_pend = 1; wr_data = 4'hF; step(1); wr_pend = 0; step(1);
    chk("R8 ch3 tx above level", src2[2], 0);
    tx_trig = 0; tx_count = 255; rx_trig = 0; rx_count = 2; step(1);
    chk("R8 ch3 rx level 2", src2[0], 1);
    chk("R8 ch0 rx level 32 not met", src_q[0], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule